// File: doc/BRIEF.md
# Field-Configurable Sum-of-Products Logic Array

The block is a small configurable combinational logic array built around a fixed OR plane. Ten primary inputs and six pin-side feedback inputs make up sixteen array inputs. Each array input is offered to every product term in both its true and its complemented form. A configuration map decides which of those literals each AND term uses. Eight outputs each own eight product terms. Seven of them are summed and the sum is inverted to form the output data. The eighth term drives that output's enable. No term is shared between outputs.

The map is 2048 bits long and arrives serially on a configuration clock while a load strobe is high. While the strobe is high, every output enable is forced low. The feedback bus carries the pin value of six of the outputs: the output value when that pin is enabled, and an external value when it is not. A disabled output can therefore serve as an extra input. Logic can also take a second pass through the array. Configurations that close a combinational loop are not supported.

Top module: `pal_array`

## Requirements
- R1: While rst_n is low, the map is cleared to all zeros. After reset every product term is 0, so oe is 8'h00 and dout is 8'hFF.
- R2: The bit at map index t*32+2*i governs the true form of array input i in term t. The bit at t*32+2*i+1 governs its complement. Array inputs 0..9 are prim_in[0..9] and inputs 10..15 are fb_pin[0..5]. A map bit of 1 disconnects the literal. A term is the AND of its connected literals, and a term with every literal disconnected is 1.
- R3: A term that connects both the true and the complemented form of the same input is 0.
- R4: dout[o] is the complement of the OR of terms o*8+1 through o*8+7. It depends on no other term.
- R5: Outside a load, oe[o] equals term o*8.
- R6: fb_pin bits enter the array as inputs 10..15 and act like any primary input.
- R7: On each rising cfg_clk edge with cfg_load high, the map shifts toward higher indices and cfg_data enters at index 0. After 2048 shifts, the first bit sent sits at index 2047, so the map is loaded MSB-first.
- R8: While cfg_load is high, oe is 8'h00. Once the strobe is low, the newly shifted map is in force.
- R9: With cfg_load low, cfg_clk edges and cfg_data have no effect on the map or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the map |
| cfg_load | input | 1 | Load strobe; shift enable and output disable |
| cfg_data | input | 1 | Serial configuration bit |
| prim_in | input | 10 | Primary array inputs |
| fb_pin | input | 6 | Pin-side values of the six feedback outputs |
| dout | output | 8 | Inverted sum-of-products per output |
| oe | output | 8 | Output enable per output |

## Verification
The array is purely combinational from prim_in and fb_pin to dout and oe. The bench therefore applies each vector on the falling cfg_clk edge and samples 2 ns later, within the same low phase. Map bits move only on rising edges while cfg_load is high. After the last shift edge, the strobe drops on the next falling edge, and the new configuration is sampled within that same half cycle. The disable checks are taken in the low phase of a cycle whose strobe is high, with the previous configuration driving enables. The ignore checks toggle cfg_data across several rising edges with the strobe low, then compare the outputs to the values from before those edges.

// File: rtl/pal_pkg.sv
package pal_pkg;
   localparam int PAL_N_PRIM   = 10;
   localparam int PAL_N_FB     = 6;
   localparam int PAL_N_OUT    = 8;
   localparam int PAL_SUM_TERMS = 7;
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
   parameter int MAP_W = 2048
) (
   input  logic             cfg_clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic             cfg_data,
   output logic [MAP_W-1:0] map_q
);
   initial assert (MAP_W >= 2) else $error("pal_cfg_chain: MAP_W too small");

   always_ff @(posedge cfg_clk or negedge rst_n) begin
      if (!rst_n)
         map_q <= '0;
      else if (cfg_load)
         map_q <= {map_q[MAP_W-2:0], cfg_data};
   end
endmodule

// File: rtl/pal_and_term.sv
module pal_and_term #(
   parameter int LIT_W = 32
) (
   input  logic [LIT_W-1:0] lits,
   input  logic [LIT_W-1:0] cut,
   output logic             term
);
   // a cut literal is forced high so it drops out of the AND
   assign term = &(lits | cut);
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
   parameter int LIT_W     = 32,
   parameter int SUM_TERMS = 7,
   localparam int CELL_TERMS = SUM_TERMS + 1
) (
   input  logic [LIT_W-1:0]            lits,
   input  logic [CELL_TERMS*LIT_W-1:0] cuts,
   output logic                        dout,
   output logic                        oe_raw
);
   initial assert (SUM_TERMS >= 1) else $error("pal_out_cell: need a sum term");

   logic [CELL_TERMS-1:0] terms;

   for (genvar j = 0; j < CELL_TERMS; j++) begin : g_term
      pal_and_term #(.LIT_W(LIT_W)) u_term (
         .lits (lits),
         .cut  (cuts[j*LIT_W +: LIT_W]),
         .term (terms[j])
      );
   end

   assign oe_raw = terms[0];
   assign dout   = ~(|terms[CELL_TERMS-1:1]);
endmodule

// File: rtl/pal_array.sv
module pal_array
   import pal_pkg::*;
#(
   parameter int N_PRIM    = PAL_N_PRIM,
   parameter int N_FB      = PAL_N_FB,
   parameter int N_OUT     = PAL_N_OUT,
   parameter int SUM_TERMS = PAL_SUM_TERMS,
   localparam int N_IN       = N_PRIM + N_FB,
   localparam int LIT_W      = 2 * N_IN,
   localparam int CELL_TERMS = SUM_TERMS + 1,
   localparam int CELL_W     = CELL_TERMS * LIT_W,
   localparam int MAP_W      = N_OUT * CELL_W
) (
   input  logic              cfg_clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic              cfg_data,
   input  logic [N_PRIM-1:0] prim_in,
   input  logic [N_FB-1:0]   fb_pin,
   output logic [N_OUT-1:0]  dout,
   output logic [N_OUT-1:0]  oe
);
   initial begin
      assert (N_FB <= N_OUT) else $error("pal_array: more feedback than outputs");
      assert (N_PRIM >= 1) else $error("pal_array: no primary inputs");
      assert (MAP_W <= 65536) else $error("pal_array: map too large");
   end

   logic [MAP_W-1:0] cfg_map;
   logic [N_IN-1:0]  in_vec;
   logic [LIT_W-1:0] lits;
   logic [N_OUT-1:0] oe_raw;

   pal_cfg_chain #(.MAP_W(MAP_W)) u_chain (
      .cfg_clk  (cfg_clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_data (cfg_data),
      .map_q    (cfg_map)
   );

   assign in_vec = {fb_pin, prim_in};

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lits[2*i]   = in_vec[i];
      assign lits[2*i+1] = ~in_vec[i];
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      pal_out_cell #(.LIT_W(LIT_W), .SUM_TERMS(SUM_TERMS)) u_cell (
         .lits   (lits),
         .cuts   (cfg_map[o*CELL_W +: CELL_W]),
         .dout   (dout[o]),
         .oe_raw (oe_raw[o])
      );
   end

   assign oe = oe_raw & {N_OUT{~cfg_load}};
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
   parameter int MAP_W = 2048,
   parameter int N_OUT = 8,
   parameter int LIT_W = 32
) (
   input logic             cfg_clk,
   input logic             rst_n,
   input logic             cfg_load,
   input logic             cfg_data,
   input logic [MAP_W-1:0] cfg_map,
   input logic [N_OUT-1:0] oe
);
   // R1
   reset_clears_map_chk: assert property (@(posedge cfg_clk)
      !rst_n |-> (cfg_map == '0));

   // R7
   shift_entry_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      cfg_load |=> (cfg_map[0] == $past(cfg_data)));

   // R8
   load_disables_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      cfg_load |-> (oe == '0));

   // R9
   idle_map_stable_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !cfg_load |=> $stable(cfg_map));

   // R5
   open_enable_term_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (!cfg_load && (&cfg_map[LIT_W-1:0])) |-> oe[0]);
endmodule

bind pal_array pal_array_chk #(.MAP_W(MAP_W), .N_OUT(N_OUT), .LIT_W(LIT_W)) u_chk (
   .cfg_clk  (cfg_clk),
   .rst_n    (rst_n),
   .cfg_load (cfg_load),
   .cfg_data (cfg_data),
   .cfg_map  (cfg_map),
   .oe       (oe)
);

// File: tb/sim_pal_array.sv
module sim_pal_array;
   localparam int CLK_PERIOD = 10;
   localparam int MAP_W = 2048;
   localparam int NVEC = 6;

   // stimulus {prim_in, fb_pin} and expected {dout, oe} for configuration A
   localparam logic [31:0] VEC [NVEC] = '{
      {10'h000, 6'h00, 8'hF5, 8'h0D},
      {10'h003, 6'h01, 8'hF0, 8'h0D},
      {10'h204, 6'h00, 8'hF7, 8'h0F},
      {10'h21C, 6'h3E, 8'hF5, 8'h0F},
      {10'h3FF, 6'h3F, 8'hF0, 8'h0F},
      {10'h001, 6'h00, 8'hF5, 8'h0D}
   };

   logic             cfg_clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_load = 1'b0;
   logic             cfg_data = 1'b0;
   logic [9:0]       prim_in = '0;
   logic [5:0]       fb_pin = '0;
   logic [7:0]       dout;
   logic [7:0]       oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   pal_array u0 (
      .cfg_clk (cfg_clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_data (cfg_data),
      .prim_in (prim_in), .fb_pin (fb_pin), .dout (dout), .oe (oe)
   );

   always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] open_term();
      return 32'hFFFF_FFFF;
   endfunction

   // configuration A (R2, R3, R4, R5, R6)
   function automatic logic [MAP_W-1:0] map_a();
      logic [MAP_W-1:0] m = '0;
      logic [31:0] t;
      m[0*32 +: 32] = open_term();
      t = open_term(); t[0] = 1'b0; t[2] = 1'b0; m[1*32 +: 32] = t;
      t = open_term(); t[18] = 1'b0; m[8*32 +: 32] = t;
      t = open_term(); t[5] = 1'b0; m[9*32 +: 32] = t;
      t = open_term(); t[6] = 1'b0; t[8] = 1'b0; m[10*32 +: 32] = t;
      m[16*32 +: 32] = open_term();
      t = open_term(); t[20] = 1'b0; m[17*32 +: 32] = t;
      m[24*32 +: 32] = open_term();
      m[25*32 +: 32] = open_term();
      return m;
   endfunction

   // configuration B: all open except two bits near both ends of the map (R7)
   function automatic logic [MAP_W-1:0] map_b();
      logic [MAP_W-1:0] m = '1;
      m[0] = 1'b0;
      m[56*32+31] = 1'b0;
      return m;
   endfunction

   task automatic load_map(input logic [MAP_W-1:0] m, input bit chk_dis);
      for (int k = MAP_W-1; k >= 0; k--) begin
         @(negedge cfg_clk);
         cfg_load = 1'b1;
         cfg_data = m[k];
         if (chk_dis && (k == MAP_W-1 || k == 5)) begin
            #2 check8("R8 oe during load", oe, 8'h00);
         end
      end
      @(negedge cfg_clk);
      cfg_load = 1'b0;
      cfg_data = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*300000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d_hold, o_hold;
      // R1 reset state
      #3;
      check8("R1 oe in reset", oe, 8'h00);
      check8("R1 dout in reset", dout, 8'hFF);
      repeat (2) @(negedge cfg_clk);
      rst_n = 1'b1;
      #2;
      check8("R1 oe after reset", oe, 8'h00);
      check8("R1 dout after reset", dout, 8'hFF);

      load_map(map_a(), 1'b0);
      for (int v = 0; v < NVEC; v++) begin
         prim_in = VEC[v][31:22];
         fb_pin  = VEC[v][21:16];
         #2;
         check8("R2/R3/R4/R6 dout vector", dout, VEC[v][15:8]);
         check8("R5 oe vector", oe, VEC[v][7:0]);
         @(negedge cfg_clk);
      end

      // R9 idle edges with toggling data leave everything unchanged
      prim_in = 10'h204; fb_pin = 6'h00;
      #2;
      d_hold = dout; o_hold = oe;
      for (int k = 0; k < 40; k++) begin
         @(negedge cfg_clk);
         cfg_data = ~cfg_data;
      end
      #2;
      check8("R9 dout after idle edges", dout, d_hold);
      check8("R9 oe after idle edges", oe, o_hold);
      check8("R9 dout value", dout, 8'hF7);
      cfg_data = 1'b0;

      // R8 disable while loading configuration B, then R7 bit order
      load_map(map_b(), 1'b1);
      prim_in = 10'h001; fb_pin = 6'h00;
      #2;
      check8("R7 oe with p0=1 fb5=0", oe, 8'hFF);
      check8("R7 dout all open", dout, 8'h00);
      @(negedge cfg_clk);
      prim_in = 10'h000; fb_pin = 6'h20;
      #2;
      check8("R7 oe with p0=0 fb5=1", oe, 8'h7E);
      check8("R4 dout ignores enable terms", dout, 8'h00);

      // R1 reset again clears the map
      rst_n = 1'b0;
      #2;
      check8("R1 oe on reset reassert", oe, 8'h00);
      check8("R1 dout on reset reassert", dout, 8'hFF);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule